// File: doc/BRIEF.md
# Change Coin Dispenser

The block pays out change after a sale. A one-cycle purchase strobe arrives with a one-bit item code. The block looks up that item's coin counts, which are fixed by parameters and computed before synthesis, and loads them into three down-counters, one for each coin value. After that it pulses one coin line per clock cycle until all three counters are empty. It serves the most valuable coin first, so it never pays a lower coin while a higher one is still owed.

A busy flag covers the whole payout. A single-cycle done pulse marks its end. While the block is busy it ignores both the item code and any further strobes. An item whose counts are all zero still completes: it shows done without paying any coin. The counts are 4-bit, so each item can specify up to 15 coins per value.

Top module: `coin_change_dispenser`

## Requirements
- R1: `coin_o` has one bit per coin value: bit 2 is the highest value, bit 1 the middle and bit 0 the lowest. At most one bit is high in any cycle, and each high cycle stands for one coin.
- R2: A rising clock edge where `buy_i` is high and `busy_o` is low accepts a purchase. `item_i` = 0 selects the counts in `ITEM0_CNT` and `item_i` = 1 selects those in `ITEM1_CNT`. In each 12-bit parameter, the nibble at bits [4d+3:4d] is the count for coin bit d.
- R3: The first coin pulse is in the cycle right after the accepting edge. Coins follow back to back, one per cycle, and the number of pulses on each bit equals the selected count.
- R4: All pulses of a higher coin come before any pulse of a lower coin.
- R5: Changes on `item_i` after the accepting edge have no effect on the payout.
- R6: A `buy_i` strobe while `busy_o` is high is ignored, and this includes the done cycle.
- R7: `busy_o` goes high in the cycle after the accepting edge and stays high through the done cycle. It is low in the cycle after that, and no coin or done output appears while it is low.
- R8: `done_o` is high for exactly one cycle, the cycle after the last coin pulse.
- R9: For an item with all counts zero, `busy_o` and `done_o` are both high in the cycle after acceptance, and no coin is paid.
- R10: While `rst_ni` is low, `coin_o`, `busy_o` and `done_o` are zero. Asserting reset in the middle of a payout aborts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buy_i | input | 1 | Purchase strobe |
| item_i | input | 1 | Item code, sampled only on acceptance |
| coin_o | output | 3 | One pulse per coin; bit 2 is the highest value |
| busy_o | output | 1 | Payout in progress |
| done_o | output | 1 | One-cycle end-of-payout pulse |

## Verification
For a purchase accepted at edge E:
- `busy_o` and the first coin are due in the cycle after E.
- Each later coin follows one cycle apart.
- `done_o` is due one cycle after the last coin, which is cycle 1 + total coins for the item.
- `busy_o` is low one cycle after that.

The driver pushes one expected `{done, coin}` entry for every cycle of that window into a queue. The monitor samples on the falling edge. It pops one entry per busy cycle and requires all outputs to be quiet in idle cycles. Because of this, a coin that comes one cycle early or late, or out of order, shows up as a mismatch at the exact cycle where it occurs. Per-bit pulse totals are checked once `busy_o` has dropped.

// File: rtl/coin_pkg.sv
package coin_pkg;
  localparam int NUM_DENOM = 3;
  localparam int DENOM_HI  = 2;
  localparam int DENOM_MID = 1;
  localparam int DENOM_LO  = 0;
endpackage

// File: rtl/coin_item_sel.sv
module coin_item_sel #(
  parameter int CNT_W = 4,
  parameter int N     = coin_pkg::NUM_DENOM,
  parameter logic [N*CNT_W-1:0] ITEM0_CNT = '0,
  parameter logic [N*CNT_W-1:0] ITEM1_CNT = '0
) (
  input  logic                     item_i,
  output logic [N-1:0][CNT_W-1:0]  cnt_o
);
  for (genvar d = 0; d < N; d++) begin : g_sel
    assign cnt_o[d] = item_i ? ITEM1_CNT[d*CNT_W +: CNT_W] : ITEM0_CNT[d*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/coin_down_ctr.sv
module coin_down_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             nz_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign nz_o = (cnt_q != '0);

  // an empty counter stays empty until reloaded
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);

  // each grant removes exactly one coin
  assert_one_per_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dec_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/coin_prio_pick.sv
module coin_prio_pick #(
  parameter int N = coin_pkg::NUM_DENOM
) (
  input  logic         en_i,
  input  logic [N-1:0] nz_i,
  output logic [N-1:0] gnt_o
);
  // highest non-empty denomination wins
  always_comb begin
    gnt_o = '0;
    for (int d = N - 1; d >= 0; d--) begin
      if (en_i && nz_i[d] && gnt_o == '0) gnt_o[d] = 1'b1;
    end
  end
endmodule

// File: rtl/coin_change_dispenser.sv
module coin_change_dispenser #(
  parameter int CNT_W = 4,
  parameter logic [coin_pkg::NUM_DENOM*CNT_W-1:0] ITEM0_CNT = 12'h21F,
  parameter logic [coin_pkg::NUM_DENOM*CNT_W-1:0] ITEM1_CNT = 12'h000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       buy_i,
  input  logic       item_i,
  output logic [2:0] coin_o,
  output logic       busy_o,
  output logic       done_o
);
  import coin_pkg::*;
  localparam int N = NUM_DENOM;

  logic                    busy_q;
  logic                    accept;
  logic [N-1:0]            nz;
  logic [N-1:0]            gnt;
  logic [N-1:0][CNT_W-1:0] load_cnt;

  assign accept = buy_i && !busy_q;
  assign done_o = busy_q && (nz == '0);
  assign busy_o = busy_q;
  assign coin_o = gnt;

  coin_item_sel #(
    .CNT_W(CNT_W), .N(N), .ITEM0_CNT(ITEM0_CNT), .ITEM1_CNT(ITEM1_CNT)
  ) u_sel (
    .item_i (item_i),
    .cnt_o  (load_cnt)
  );

  for (genvar d = 0; d < N; d++) begin : g_ctr
    coin_down_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (accept),
      .load_val_i (load_cnt[d]),
      .dec_i      (gnt[d]),
      .nz_o       (nz[d])
    );
  end

  coin_prio_pick #(.N(N)) u_pick (
    .en_i  (busy_q),
    .nz_i  (nz),
    .gnt_o (gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (accept) busy_q <= 1'b1;
    else if (done_o) busy_q <= 1'b0;
  end

  assert_coin_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(coin_o));

  assert_no_hi_after_mid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_o[DENOM_MID] |=> !coin_o[DENOM_HI]);

  assert_no_upper_after_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_o[DENOM_LO] |=> !coin_o[DENOM_HI] && !coin_o[DENOM_MID]);

  assert_busy_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_done_ends_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (coin_o == '0 && !done_o));
endmodule

// File: tb/coin_change_dispenser_tb.sv
module coin_change_dispenser_tb;
  localparam logic [11:0] P0 = 12'h21F;  // hi=2 mid=1 lo=15
  localparam logic [11:0] P1 = 12'h000;  // all zero

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buy = 1'b0;
  logic       item = 1'b0;
  logic [2:0] coin;
  logic       busy, done;

  int         checks = 0;
  int         errors = 0;
  logic [3:0] exp_q[$];
  logic [3:0] e;
  int         pulses[3];
  string      tag = "R1 R3 R4 R8";

  always #5 clk = ~clk;

  coin_change_dispenser #(.CNT_W(4), .ITEM0_CNT(P0), .ITEM1_CNT(P1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .buy_i(buy), .item_i(item),
    .coin_o(coin), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_cnt(input bit it, input int d);
    return it ? int'(P1[d*4 +: 4]) : int'(P0[d*4 +: 4]);
  endfunction

  task automatic push_expect(input bit it);
    for (int d = 2; d >= 0; d--)
      for (int k = 0; k < exp_cnt(it, d); k++) exp_q.push_back({1'b0, 3'(1 << d)});
    exp_q.push_back(4'b1000);
    for (int d = 0; d < 3; d++) pulses[d] = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (exp_q.size() == 0) chk(1'b0, "R7", "busy with nothing expected", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk({done, coin} == e, tag, "done/coin pattern", int'({done, coin}), int'(e));
        end
      end else begin
        chk(coin == 3'b0 && !done, "R7", "output while idle", int'({done, coin}), 0);
      end
      for (int d = 0; d < 3; d++) if (coin[d]) pulses[d]++;
    end
  end

  task automatic purchase(input bit it, input bit disturb);
    bit seen;
    @(negedge clk);
    buy = 1'b1; item = it;
    tag = disturb ? "R5 R1 R3 R4 R8" : (it ? "R9 R8" : "R1 R2 R3 R4 R8");
    push_expect(it);
    @(negedge clk);
    chk(busy, "R2 R7", "busy after accept", int'(busy), 1);
    if (disturb) item = ~it;  // keep strobing with the other item
    else buy = 1'b0;
    seen = 1'b0;
    while (!seen) begin
      if (done) seen = 1'b1;
      @(negedge clk);
    end
    buy = 1'b0;
    chk(!busy, "R7", "busy after done cycle", int'(busy), 0);
    @(negedge clk);
    chk(!busy, "R6", "strobe during busy/done accepted", int'(busy), 0);
    for (int d = 0; d < 3; d++)
      chk(pulses[d] == exp_cnt(it, d), it ? "R9" : "R3", "pulse total", pulses[d], exp_cnt(it, d));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(coin == 3'b0 && !busy && !done, "R10", "outputs in reset", int'({busy, done, coin}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    purchase(1'b0, 1'b0);   // nonzero item
    purchase(1'b1, 1'b0);   // zero item
    purchase(1'b0, 1'b1);   // item flips and strobes while busy
    purchase(1'b1, 1'b0);
    purchase(1'b0, 1'b0);   // back to back

    // abort in mid payout
    @(negedge clk);
    buy = 1'b1; item = 1'b0; tag = "R1 R3 R4";
    push_expect(1'b0);
    @(negedge clk);
    buy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(coin == 3'b0 && !busy && !done, "R10", "outputs after mid reset", int'({busy, done, coin}), 0);
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R10", "idle after reset release", int'(busy), 0);
    purchase(1'b0, 1'b0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule